// File: doc/BRIEF.md
# PLL Clock Mode Controller

This block picks the CPU clock for a chip whose frequency multiplier loop is an analog macro outside the design. The loop output arrives on `mul_clk_i`. The controller decides which clock drives the CPU and switches between the candidates without producing a runt pulse. There are three candidates: the reference input itself, the reference halved, and the multiplied clock halved. The divide-by-two stage stays on the multiplied path in every mode except full disable.

A strap pin is sampled once, on the first reference edge after reset is released. A low strap turns the loop off for the whole session, and the reference is then passed straight through. With the strap high, the chip starts in bypass at half the reference rate. Software programs a 4-bit multiplier through a small register bus. Every accepted write restarts a settling timer. The CPU clock stays on the halved reference until that timer runs out, and only then moves to the multiplied path.

Software may write the multiplier only while the watchdog is disabled. A write made while the watchdog is enabled is dropped and raises a sticky error flag. Software clears that flag by writing 1 to bit 0 at the second register address. The stable flag tells software when the watchdog may be turned back on.

Top module: `pll_clk_mode_ctrl`

## Requirements
- R1: If `pll_on_strap_i` is low on the first `clk_i` rising edge after reset is released, `mode_o` reads 0 (raw source) and `cpu_clk_o` runs at the `clk_i` rate.
- R2: If the strap is high, then after reset `ratio_o` = 0, `stable_o` = 1, `wr_err_o` = 0, `mode_o` = 1 (halved source), and `cpu_clk_o` runs at half the `clk_i` rate.
- R3: A write with `reg_sel_i` = 0 while `wdog_en_i` = 0 loads `reg_wdata_i` into `ratio_o` on the next edge. Once settled, a non-zero value n gives `mode_o` = 2 (multiplied source) and a `cpu_clk_o` rate of `mul_clk_i`/2.
- R4: After an accepted ratio write, `stable_o` is low for exactly SETTLE_CYCLES `clk_i` cycles, counted from the write edge, and is high from the edge after that.
- R5: While `stable_o` is low, `mode_o` is never 2, so the CPU stays on the halved reference.
- R6: A ratio write while `wdog_en_i` = 1 leaves `ratio_o` and `stable_o` unchanged and sets `wr_err_o`.
- R7: `wr_err_o` stays set until a write with `reg_sel_i` = 1 and `reg_wdata_i[0]` = 1. A write there with bit 0 = 0 does not clear it.
- R8: Writing ratio 0 returns the clock to the halved reference (`mode_o` = 1).
- R9: A ratio write accepted while settling is already in progress restarts the settling count from zero.
- R10: In disabled mode, ratio writes still load `ratio_o`, but `mode_o` stays 0 and `cpu_clk_o` stays at the `clk_i` rate.
- R11: Source switching is break-before-make: at most one source gate is open at any time, and `cpu_clk_o` shows no high pulse shorter than the shortest half-period of the source being used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; raw CPU clock source and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_on_strap_i | input | 1 | Loop enable strap; low at capture disables the loop |
| mul_clk_i | input | 1 | Multiplied clock from the external loop |
| wdog_en_i | input | 1 | Watchdog enable state; blocks ratio writes when high |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 ratio, 1 error clear |
| reg_wdata_i | input | RATIO_W | Write data |
| cpu_clk_o | output | 1 | Selected CPU clock |
| mode_o | output | 2 | Active source: 0 raw, 1 halved reference, 2 halved multiplied |
| ratio_o | output | RATIO_W | Current multiplier value |
| stable_o | output | 1 | High when no settling period is running |
| wr_err_o | output | 1 | Sticky rejected-write flag |

## Verification
The CPU clock rate is measured by counting `cpu_clk_o` edges over a fixed window of reference cycles. In that window the raw, halved and multiplied paths give counts of 64, 32 and 32·n, so any mix-up between the sources shows up. Directed sequences run each mode after a strap-low and a strap-high reset. They also probe the settling boundary at one cycle before and at the exact cycle, a restart issued mid-settling, and the ratio-0 return. Randomized ratio values, mixed with random watchdog states, then show whether the interlock and the sticky flag follow an independent model. Throughout the run, the shortest high pulse on the output is tracked to expose any runt caused by switching.

// File: rtl/pll_ctrl_pkg.sv
`timescale 1ns/1ps
package pll_ctrl_pkg;
  typedef enum logic [1:0] {
    SRC_RAW  = 2'd0,
    SRC_HALF = 2'd1,
    SRC_MUL  = 2'd2
  } clk_src_e;

  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;
endpackage

// File: rtl/pll_clk_div2.sv
`timescale 1ns/1ps
module pll_clk_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign clk_o = half_q;
endmodule

// File: rtl/pll_ratio_regs.sv
`timescale 1ns/1ps
module pll_ratio_regs #(
  parameter int RATIO_W       = 4,
  parameter int SETTLE_CYCLES = 131072
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [RATIO_W-1:0] wdata_i,
  input  logic               wdog_en_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               stable_o,
  output logic               err_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               settling_q;
  logic               err_q;
  logic               ratio_wr, accept, reject, clear;

  assign ratio_wr = we_i && !sel_i;
  assign accept   = ratio_wr && !wdog_en_i;
  assign reject   = ratio_wr && wdog_en_i;
  assign clear    = we_i && sel_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ratio_q <= '0;
    else if (accept) ratio_q <= wdata_i;
  end

  // restart on every accepted write, even mid-settle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      settling_q <= 1'b0;
    end else if (accept) begin
      cnt_q      <= '0;
      settling_q <= 1'b1;
    end else if (settling_q) begin
      if (cnt_q == CNT_LAST) settling_q <= 1'b0;
      else                   cnt_q      <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
    else if (clear)  err_q <= 1'b0;
  end

  assign ratio_o  = ratio_q;
  assign stable_o = !settling_q;
  assign err_o    = err_q;
endmodule

// File: rtl/pll_glitchless_mux.sv
`timescale 1ns/1ps
module pll_glitchless_mux #(
  parameter int N     = 3,
  parameter int SEL_W = 2
) (
  input  logic [N-1:0]     clk_src_i,
  input  logic             rst_ni,
  input  logic             sel_vld_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o,
  output logic [N-1:0]     en_o
);
  logic [N-1:0] en;
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [1:0]   sync_q;
    logic         en_q;
    logic [N-1:0] others;
    logic         req;

    assign others = en & ~(N'(1) << g);
    // open only when every other gate has closed
    assign req    = sel_vld_i && (sel_i == SEL_W'(g)) && (others == '0);

    always_ff @(posedge clk_src_i[g] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 2'b00;
      else         sync_q <= {sync_q[0], req};
    end

    // gate changes only while the source is low
    always_ff @(negedge clk_src_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= sync_q[1];
    end

    assign en[g]    = en_q;
    assign gated[g] = clk_src_i[g] & en_q;
  end

  assign clk_o = |gated;
  assign en_o  = en;
endmodule

// File: rtl/pll_clk_mode_ctrl.sv
`timescale 1ns/1ps
module pll_clk_mode_ctrl
  import pll_ctrl_pkg::*;
#(
  parameter int RATIO_W       = 4,
  parameter int SETTLE_CYCLES = 131072
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pll_on_strap_i,
  input  logic               mul_clk_i,
  input  logic               wdog_en_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [RATIO_W-1:0] reg_wdata_i,
  output logic               cpu_clk_o,
  output logic [1:0]         mode_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               stable_o,
  output logic               wr_err_o
);
  logic         cap_done_q;
  logic         loop_off_q;
  logic         half_ref_clk;
  logic         half_mul_clk;
  logic         stable;
  logic [RATIO_W-1:0] ratio;
  clk_src_e     mode;
  logic [NUM_SRC-1:0] src_clks;
  logic [NUM_SRC-1:0] src_en;

  // strap captured once, first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_done_q <= 1'b0;
      loop_off_q <= 1'b0;
    end else if (!cap_done_q) begin
      cap_done_q <= 1'b1;
      loop_off_q <= !pll_on_strap_i;
    end
  end

  pll_ratio_regs #(
    .RATIO_W      (RATIO_W),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .wdog_en_i(wdog_en_i),
    .ratio_o  (ratio),
    .stable_o (stable),
    .err_o    (wr_err_o)
  );

  pll_clk_div2 u_div_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clk_o (half_ref_clk)
  );

  pll_clk_div2 u_div_mul (
    .clk_i (mul_clk_i),
    .rst_ni(rst_ni),
    .clk_o (half_mul_clk)
  );

  always_comb begin
    if (loop_off_q)                  mode = SRC_RAW;
    else if (ratio != '0 && stable)  mode = SRC_MUL;
    else                             mode = SRC_HALF;
  end

  assign src_clks[SRC_RAW]  = clk_i;
  assign src_clks[SRC_HALF] = half_ref_clk;
  assign src_clks[SRC_MUL]  = half_mul_clk;

  pll_glitchless_mux #(
    .N    (NUM_SRC),
    .SEL_W(SRC_W)
  ) u_mux (
    .clk_src_i(src_clks),
    .rst_ni   (rst_ni),
    .sel_vld_i(cap_done_q),
    .sel_i    (mode),
    .clk_o    (cpu_clk_o),
    .en_o     (src_en)
  );

  assign mode_o   = mode;
  assign ratio_o  = ratio;
  assign stable_o = stable;
endmodule

// File: rtl/pll_clk_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pll_clk_mode_ctrl_chk #(
  parameter int RATIO_W = 4,
  parameter int N_SRC   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wdog_en_i,
  input logic               reg_we_i,
  input logic               reg_sel_i,
  input logic [RATIO_W-1:0] reg_wdata_i,
  input logic [1:0]         mode_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               stable_o,
  input logic               wr_err_o,
  input logic [N_SRC-1:0]   src_en
);
  AST_RATIO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i && !wdog_en_i |=> ratio_o == $past(reg_wdata_i)); // R3
  AST_SETTLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i && !wdog_en_i |=> !stable_o); // R4
  AST_MUL_AFTER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |-> stable_o); // R5
  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i && wdog_en_i |=> $stable(ratio_o) && $stable(stable_o)); // R6
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i && wdog_en_i |=> wr_err_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o && !(reg_we_i && reg_sel_i && reg_wdata_i[0]) |=> wr_err_o); // R7
  AST_ZERO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o == '0 |-> mode_o != 2'd2); // R8
  AST_BREAK_MAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_en)); // R11
endmodule

bind pll_clk_mode_ctrl pll_clk_mode_ctrl_chk #(
  .RATIO_W(RATIO_W),
  .N_SRC  (pll_ctrl_pkg::NUM_SRC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wdog_en_i  (wdog_en_i),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .mode_o     (mode_o),
  .ratio_o    (ratio_o),
  .stable_o   (stable_o),
  .wr_err_o   (wr_err_o),
  .src_en     (src_en)
);

// File: tb/pll_clk_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_clk_mode_ctrl_tb_top;
  localparam int RW  = 4;
  localparam int S   = 256;
  localparam int WIN = 64;

  logic clk = 1'b0, mul_clk = 1'b0, rst_n = 1'b0, strap = 1'b1;
  logic wdog = 1'b0, we = 1'b0, sel = 1'b0;
  logic [RW-1:0] wd = '0;
  logic cpu_clk, stable, err;
  logic [1:0] mode;
  logic [RW-1:0] ratio;

  real mul_half = 2.5;
  int  n_tests = 0, n_fail = 0;
  int  cpu_edges = 0;
  bit  meas_on = 1'b0;
  bit  done = 1'b0;
  realtime t_rise = 0.0;
  real min_hi = 1000.0;

  int m_ratio = 0;
  bit m_err = 1'b0;
  bit m_off = 1'b0;

  pll_clk_mode_ctrl #(.RATIO_W(RW), .SETTLE_CYCLES(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pll_on_strap_i(strap), .mul_clk_i(mul_clk),
    .wdog_en_i(wdog), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd),
    .cpu_clk_o(cpu_clk), .mode_o(mode), .ratio_o(ratio), .stable_o(stable),
    .wr_err_o(err)
  );

  always #2.5 clk = ~clk;
  always begin
    #(mul_half);
    mul_clk = ~mul_clk;
  end

  always @(posedge cpu_clk) begin
    t_rise = $realtime;
    if (meas_on) cpu_edges++;
  end
  always @(negedge cpu_clk) begin
    if (rst_n && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, int act, int lo, int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int exp_mode();
    if (m_off) return 0;
    return (m_ratio != 0) ? 2 : 1;
  endfunction

  function automatic int exp_edges();
    if (m_off) return WIN;
    if (m_ratio == 0) return WIN / 2;
    return WIN * m_ratio / 2;
  endfunction

  task automatic do_reset(bit strap_v);
    rst_n = 1'b0;
    strap = strap_v;
    we = 1'b0;
    wdog = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_ratio = 0;
    m_err = 1'b0;
    m_off = !strap_v;
    mul_half = 2.5;
  endtask

  task automatic bus_wr(bit s, int d);
    we = 1'b1;
    sel = s;
    wd = RW'(d);
    @(negedge clk);
    we = 1'b0;
    if (!s) begin
      if (!wdog) begin
        m_ratio = d;
        if (d != 0) mul_half = 2.5 / d;
      end else m_err = 1'b1;
    end else if (d[0]) m_err = 1'b0;
  endtask

  task automatic measure(string req);
    repeat (40) @(negedge clk);
    cpu_edges = 0;
    meas_on = 1'b1;
    repeat (WIN) @(negedge clk);
    meas_on = 1'b0;
    chk_range(req, cpu_edges, exp_edges() - 3, exp_edges() + 3);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));

    // disabled mode
    do_reset(1'b0);
    chk("R1 mode raw", int'(mode), 0);
    measure("R1 raw rate");
    bus_wr(1'b0, 5);
    chk("R10 ratio loaded", int'(ratio), 5);
    repeat (S + 2) @(negedge clk);
    chk("R10 mode stays raw", int'(mode), 0);
    measure("R10 raw rate kept");

    // bypass after reset
    do_reset(1'b1);
    chk("R2 ratio", int'(ratio), 0);
    chk("R2 stable", int'(stable), 1);
    chk("R2 err", int'(err), 0);
    chk("R2 mode half", int'(mode), 1);
    measure("R2 half rate");

    // settle boundary
    bus_wr(1'b0, 3);
    chk("R4 stable drops", int'(stable), 0);
    chk("R5 mode half during settle", int'(mode), 1);
    repeat (S - 1) @(negedge clk);
    chk("R4 stable low at last cycle", int'(stable), 0);
    chk("R5 mode half at last cycle", int'(mode), 1);
    @(negedge clk);
    chk("R4 stable at boundary", int'(stable), 1);
    chk("R3 mode mul", int'(mode), 2);
    measure("R3 mul rate n=3");

    // restart mid-settle
    bus_wr(1'b0, 6);
    repeat (100) @(negedge clk);
    bus_wr(1'b0, 2);
    repeat (S - 1) @(negedge clk);
    chk("R9 still settling after restart", int'(stable), 0);
    @(negedge clk);
    chk("R9 stable after restarted count", int'(stable), 1);
    chk("R3 ratio 2", int'(ratio), 2);
    measure("R3 mul rate n=2");

    // interlock
    wdog = 1'b1;
    bus_wr(1'b0, 9);
    chk("R6 ratio kept", int'(ratio), 2);
    chk("R6 err set", int'(err), 1);
    chk("R6 stable kept", int'(stable), 1);
    chk("R6 mode kept", int'(mode), 2);
    wdog = 1'b0;
    bus_wr(1'b1, 0);
    chk("R7 clear with bit0=0 ignored", int'(err), 1);
    bus_wr(1'b1, 1);
    chk("R7 cleared", int'(err), 0);

    // ratio 0 back to bypass
    bus_wr(1'b0, 0);
    chk("R8 settling on zero write", int'(stable), 0);
    repeat (S + 2) @(negedge clk);
    chk("R8 mode half", int'(mode), 1);
    measure("R8 half rate");

    // high ratio directed corner
    bus_wr(1'b0, 15);
    repeat (S + 2) @(negedge clk);
    chk("R3 mode mul n=15", int'(mode), 2);
    measure("R3 mul rate n=15");

    // constrained random
    for (int it = 0; it < 8; it++) begin
      int n;
      n = $urandom_range(15, 0);
      wdog = ($urandom_range(2, 0) == 0);
      bus_wr(1'b0, n);
      chk("R6 random ratio model", int'(ratio), m_ratio);
      chk("R7 random err model", int'(err), int'(m_err));
      wdog = 1'b0;
      repeat (S + 2) @(negedge clk);
      chk("R3 random mode", int'(mode), exp_mode());
      measure("R3 random rate");
      if (m_err) begin
        bus_wr(1'b1, 1);
        chk("R7 random clear", int'(err), 0);
      end
    end

    chk_range("R11 shortest cpu high pulse ps", int'(min_hi * 1000.0), 150, 100000);

    done = 1'b1;
    finish_run();
  end
endmodule